// File: doc/BRIEF.md
# Flash Write Pulse Sequencer

This block issues the timed control-bit pattern that applies a single programming pulse to an on-chip flash array. A start request, together with a width choice (short, medium or long), launches a sequence that first arms a watchdog enable. It then raises a program-setup bit and, after a settling wait, raises the program bit for the selected pulse width. Once the pulse ends, the program bit drops first and the setup bit follows after its own wait. A final wait closes the watchdog-guarded window.

Each wait is a run-time input counted in clock cycles. The inputs are captured when a start is accepted, so the caller may change them while a pulse is running. The short width is intended for additional-programming passes. The medium and long widths serve ordinary programming, and the caller picks between them as programming progresses. The block reports a busy level and a one-cycle done strobe.

Top module: `flash_pulse_seq`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, busy_o, wdt_en_o, setup_o, prog_o and done_o are all low.
- R2: A start_i sampled high on a clock edge while busy_o is low is accepted. In the next cycle busy_o and wdt_en_o are high and setup_o and prog_o are low for exactly one cycle (the arm cycle).
- R3: After the arm cycle the outputs follow a fixed order. First, setup_o alone is high for the setup count. Next, setup_o and prog_o are both high for the pulse count. Then setup_o alone is high for the post count. Finally, setup_o and prog_o are low for the final count while busy_o stays high.
- R4: The pulse count is chosen by width_sel_i as sampled at acceptance: 0 selects t_short_i, 1 selects t_med_i, and 2 or 3 selects t_long_i.
- R5: All wait counts and width_sel_i are captured at acceptance. Changing them while busy_o is high leaves the running sequence unchanged.
- R6: A wait count of 0 lasts one cycle. Any other value N lasts N cycles.
- R7: A start_i that is high while busy_o is high is ignored, and the running sequence is not lengthened or restarted.
- R8: done_o is high for exactly one cycle, namely the cycle right after the final wait ends, with busy_o low. A start_i high in that cycle is accepted.
- R9: prog_o only rises while setup_o was already high in the previous cycle, and setup_o only falls after prog_o was already low in the previous cycle.
- R10: wdt_en_o is high in every cycle in which busy_o is high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request one write pulse sequence |
| width_sel_i | input | 2 | Pulse width choice: 0 short, 1 medium, 2/3 long |
| t_setup_i | input | 16 | Cycles from setup bit high to program bit high |
| t_short_i | input | 16 | Short pulse length in cycles |
| t_med_i | input | 16 | Medium pulse length in cycles |
| t_long_i | input | 16 | Long pulse length in cycles |
| t_post_i | input | 16 | Cycles from program bit low to setup bit low |
| t_final_i | input | 16 | Cycles from setup bit low to end of window |
| setup_o | output | 1 | Program-setup control bit |
| prog_o | output | 1 | Program control bit |
| wdt_en_o | output | 1 | Watchdog enable for the sequence window |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle strobe after the final wait |

## Verification
The bench targets zero-length waits, which a design without a one-cycle floor would either skip or let wrap to a full 65536-cycle wait. It changes every wait and the width choice in the middle of a pulse, so a design that reads the live inputs would stretch or shorten the phases. It holds start high through an entire sequence: a design that accepts it while busy would restart or lengthen the pulse, and one that refuses it in the done cycle would add a dead cycle between back-to-back pulses. Width codes 0 to 3 are each exercised, so that a code 3 falling through to the wrong width or to no pulse shows up as a wrong prog_o length.

// File: rtl/flash_pulse_pkg.sv
package flash_pulse_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ARM   = 3'd1,
    PH_SETUP = 3'd2,
    PH_PULSE = 3'd3,
    PH_POST  = 3'd4,
    PH_FINAL = 3'd5
  } phase_e;

  localparam logic [1:0] WSEL_SHORT = 2'd0;
  localparam logic [1:0] WSEL_MED   = 2'd1;
endpackage

// File: rtl/flash_pulse_wmux.sv
module flash_pulse_wmux #(
  parameter int W = 16
) (
  input  logic [1:0]   sel_i,
  input  logic [W-1:0] short_i,
  input  logic [W-1:0] med_i,
  input  logic [W-1:0] long_i,
  output logic [W-1:0] width_o
);
  import flash_pulse_pkg::*;

  always_comb begin
    unique case (sel_i)
      WSEL_SHORT: width_o = short_i;
      WSEL_MED:   width_o = med_i;
      default:    width_o = long_i;  // codes 2 and 3
    endcase
  end
endmodule

// File: rtl/flash_pulse_cnt.sv
module flash_pulse_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         last_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= (load_val_i == '0) ? ONE : load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - ONE;
  end

  assign last_o = (cnt_q == ONE);

  // zero count must still give a one-cycle phase
  assert_load_nonzero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q != '0));
endmodule

// File: rtl/flash_pulse_fsm.sv
module flash_pulse_fsm #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] t_setup_i,
  input  logic [W-1:0] t_pulse_i,
  input  logic [W-1:0] t_post_i,
  input  logic [W-1:0] t_final_i,
  input  logic         last_i,
  output logic         load_o,
  output logic [W-1:0] load_val_o,
  output logic         setup_o,
  output logic         prog_o,
  output logic         wdt_en_o,
  output logic         busy_o,
  output logic         done_o
);
  import flash_pulse_pkg::*;

  phase_e       ph_q, ph_d;
  logic [W-1:0] ts_q, tp_q, tpo_q, tf_q;
  logic         done_q;
  logic         accept;

  assign accept = (ph_q == PH_IDLE) && start_i;

  always_comb begin
    ph_d       = ph_q;
    load_o     = 1'b0;
    load_val_o = '0;
    unique case (ph_q)
      PH_IDLE:  if (start_i) ph_d = PH_ARM;
      PH_ARM: begin
        ph_d = PH_SETUP; load_o = 1'b1; load_val_o = ts_q;
      end
      PH_SETUP: if (last_i) begin
        ph_d = PH_PULSE; load_o = 1'b1; load_val_o = tp_q;
      end
      PH_PULSE: if (last_i) begin
        ph_d = PH_POST; load_o = 1'b1; load_val_o = tpo_q;
      end
      PH_POST: if (last_i) begin
        ph_d = PH_FINAL; load_o = 1'b1; load_val_o = tf_q;
      end
      PH_FINAL: if (last_i) ph_d = PH_IDLE;
      default:  ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      done_q <= 1'b0;
      ts_q   <= '0;
      tp_q   <= '0;
      tpo_q  <= '0;
      tf_q   <= '0;
    end else begin
      ph_q   <= ph_d;
      done_q <= (ph_q == PH_FINAL) && last_i;
      if (accept) begin
        ts_q  <= t_setup_i;
        tp_q  <= t_pulse_i;
        tpo_q <= t_post_i;
        tf_q  <= t_final_i;
      end
    end
  end

  assign busy_o   = (ph_q != PH_IDLE);
  assign wdt_en_o = busy_o;
  assign setup_o  = (ph_q == PH_SETUP) || (ph_q == PH_PULSE) || (ph_q == PH_POST);
  assign prog_o   = (ph_q == PH_PULSE);
  assign done_o   = done_q;

  assert_arm_cycle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (wdt_en_o && !setup_o && !prog_o));

  assert_prog_after_setup_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prog_o) |-> $past(setup_o));

  assert_setup_after_prog_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(setup_o) |-> ($past(!prog_o) && !prog_o));

  assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_busy_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !(ph_q == PH_FINAL && last_i)) |=> busy_o);

  assert_wdt_window_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_o |-> wdt_en_o);
endmodule

// File: rtl/flash_pulse_seq.sv
module flash_pulse_seq #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [1:0]   width_sel_i,
  input  logic [W-1:0] t_setup_i,
  input  logic [W-1:0] t_short_i,
  input  logic [W-1:0] t_med_i,
  input  logic [W-1:0] t_long_i,
  input  logic [W-1:0] t_post_i,
  input  logic [W-1:0] t_final_i,
  output logic         setup_o,
  output logic         prog_o,
  output logic         wdt_en_o,
  output logic         busy_o,
  output logic         done_o
);
  logic [W-1:0] pulse_w;
  logic         cnt_load;
  logic [W-1:0] cnt_val;
  logic         cnt_last;

  flash_pulse_wmux #(.W(W)) u_wmux (
    .sel_i   (width_sel_i),
    .short_i (t_short_i),
    .med_i   (t_med_i),
    .long_i  (t_long_i),
    .width_o (pulse_w)
  );

  flash_pulse_cnt #(.W(W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cnt_load),
    .load_val_i (cnt_val),
    .last_o     (cnt_last)
  );

  flash_pulse_fsm #(.W(W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .t_setup_i  (t_setup_i),
    .t_pulse_i  (pulse_w),
    .t_post_i   (t_post_i),
    .t_final_i  (t_final_i),
    .last_i     (cnt_last),
    .load_o     (cnt_load),
    .load_val_o (cnt_val),
    .setup_o    (setup_o),
    .prog_o     (prog_o),
    .wdt_en_o   (wdt_en_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );
endmodule

// File: tb/sim_flash_pulse_seq.sv
module sim_flash_pulse_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  width_sel_i = 2'd0;
  logic [15:0] t_setup_i = 16'd0, t_short_i = 16'd0, t_med_i = 16'd0;
  logic [15:0] t_long_i = 16'd0, t_post_i = 16'd0, t_final_i = 16'd0;
  logic        setup_o, prog_o, wdt_en_o, busy_o, done_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_req = "R1";
  logic [4:0] exp_q[$];   // {busy, wdt, setup, prog, done}
  logic [4:0] cur = 5'b0;

  always #2 clk_i = ~clk_i;  // 250 MHz

  flash_pulse_seq u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .width_sel_i(width_sel_i),
    .t_setup_i(t_setup_i), .t_short_i(t_short_i), .t_med_i(t_med_i),
    .t_long_i(t_long_i), .t_post_i(t_post_i), .t_final_i(t_final_i),
    .setup_o(setup_o), .prog_o(prog_o), .wdt_en_o(wdt_en_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  function automatic int eff(input logic [15:0] t);
    return (t == 16'd0) ? 1 : int'(t);
  endfunction

  task automatic push_n(input logic [4:0] pat, input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(pat);
  endtask

  task automatic compare();
    logic [4:0] act;
    act = {busy_o, wdt_en_o, setup_o, prog_o, done_o};
    checks++;
    if (act !== cur) begin
      errors++;
      $display("FAIL %s cycle %0d: got %b expected %b (busy wdt setup prog done)",
               cur_req, cycles, act, cur);
    end
  endtask

  // inputs already set for the coming edge; called at a negedge
  task automatic tick();
    if (start_i && !cur[4]) begin
      int tp;
      tp = (width_sel_i == 2'd0) ? eff(t_short_i) :
           (width_sel_i == 2'd1) ? eff(t_med_i) : eff(t_long_i);
      push_n(5'b11000, 1);
      push_n(5'b11100, eff(t_setup_i));
      push_n(5'b11110, tp);
      push_n(5'b11100, eff(t_post_i));
      push_n(5'b11000, eff(t_final_i));
      push_n(5'b00001, 1);
    end
    @(negedge clk_i);
    cur = (exp_q.size() > 0) ? exp_q.pop_front() : 5'b0;
    compare();
  endtask

  task automatic set_waits(input logic [1:0] s, input int ts, input int a,
                           input int b, input int c, input int po, input int f);
    width_sel_i = s;
    t_setup_i = 16'(ts); t_short_i = 16'(a); t_med_i = 16'(b);
    t_long_i = 16'(c); t_post_i = 16'(po); t_final_i = 16'(f);
  endtask

  task automatic drain();
    start_i = 1'b0;
    while (exp_q.size() > 0 || cur != 5'b0) tick();
    tick();
  endtask

  task automatic run(input string req);
    cur_req = req;
    start_i = 1'b1;
    tick();
    drain();
  endtask

  initial begin
    while (cycles < 200000) @(posedge clk_i) cycles++;
    errors++;
    $display("FAIL watchdog expired after %0d cycles", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    cur_req = "R1";
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      compare();
    end
    rst_ni = 1'b1;
    tick();

    // R2 R3 R10: short width, distinct phase lengths
    set_waits(2'd0, 3, 2, 5, 9, 4, 6);
    run("R3");
    // R4: each width code
    set_waits(2'd1, 2, 2, 5, 9, 3, 2);
    run("R4");
    set_waits(2'd2, 2, 2, 5, 9, 3, 2);
    run("R4");
    set_waits(2'd3, 1, 2, 5, 11, 1, 1);
    run("R4");
    // R6: zero waits
    set_waits(2'd0, 0, 0, 0, 0, 0, 0);
    run("R6");
    set_waits(2'd2, 0, 7, 7, 0, 2, 0);
    run("R6");
    // R2: arm then long setup, checked per cycle
    set_waits(2'd1, 8, 1, 3, 1, 1, 1);
    run("R2");

    // R5: change everything mid-sequence
    cur_req = "R5";
    set_waits(2'd1, 4, 3, 6, 20, 5, 3);
    start_i = 1'b1;
    tick();
    start_i = 1'b0;
    for (int i = 0; i < 5; i++) tick();
    set_waits(2'd2, 30, 1, 1, 40, 0, 25);
    drain();

    // R7 R8: start held through busy; reaccepted in the done cycle
    cur_req = "R7";
    set_waits(2'd0, 2, 3, 4, 5, 2, 2);
    start_i = 1'b1;
    for (int i = 0; i < 14; i++) begin
      if (cur[0]) cur_req = "R8";
      tick();
    end
    cur_req = "R8";
    drain();

    // R9 R10: long pulse with tight brackets
    set_waits(2'd2, 1, 1, 1, 25, 1, 1);
    run("R9");
    set_waits(2'd0, 5, 1, 2, 3, 5, 4);
    run("R10");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule